// File: doc/BRIEF.md
# Memory Access Alignment Fault Classifier

This block sits beside the address stage of a vector load/store pipeline. For every memory request it decides whether the access must be refused. A refused access takes one of two faults: a protection fault or an alignment-check fault. The decision rests on four things: the access size, the address, the instruction encoding class (legacy or extended), and the kind of access. The kind is an explicitly aligned move, an explicitly unaligned move, or an arithmetic instruction with a memory operand. For small accesses the user-mode alignment-check conditions also count.

A request is presented on one cycle with `reqValid` high. The classification is registered and appears one cycle later on `rspFault`, qualified by `rspValid`. Requests may arrive back to back, one per cycle. The block keeps no other state.

Top module: `memalign_chk_top`

## Requirements
- R1: `rspValid` equals the value `reqValid` had one cycle earlier, and it is low after reset.
- R2: `rspFault` uses the codes 2'b00 for no fault, 2'b01 for protection fault and 2'b10 for alignment-check fault. It never shows 2'b11, and it is 2'b00 whenever `rspValid` is low.
- R3: `reqSize` carries log2 of the byte count: 1, 2, 3, 4 and 5 stand for 2, 4, 8, 16 and 32 bytes. An access is misaligned when any of its lowest `reqSize` address bits is set. Codes 6 and 7 act as code 5, and code 0 is never misaligned.
- R4: A misaligned 16- or 32-byte access of kind aligned-move (`reqKind`=0) gets a protection fault. This holds in both encoding classes and in every ring and flag state.
- R5: A misaligned 16- or 32-byte arithmetic access (`reqKind`=2 or 3) with legacy encoding (`reqExt`=0) gets a protection fault.
- R6: A 16- or 32-byte arithmetic access with extended encoding (`reqExt`=1) never faults, at any address.
- R7: A 16- or 32-byte access of kind unaligned-move (`reqKind`=1) never faults, at any address.
- R8: A misaligned 2-, 4- or 8-byte access gets an alignment-check fault exactly when `chkFlag`=1, `reqRing`=3 and `ctlAlignMask`=1 all hold. Otherwise it gets no fault. Kind and encoding do not change this.
- R9: An access of 16 or 32 bytes never gets an alignment-check fault. When both fault kinds could apply, the protection fault wins.
- R10: An access that is not misaligned never faults, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 3 | log2 of the access size in bytes |
| reqExt | input | 1 | 1 = extended encoding, 0 = legacy encoding |
| reqKind | input | 2 | 0 aligned move, 1 unaligned move, 2/3 arithmetic operand |
| reqRing | input | 2 | Current privilege ring |
| chkFlag | input | 1 | Alignment-check flag from the status word |
| ctlAlignMask | input | 1 | Alignment-mask bit from the control register |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspFault | output | 2 | Fault code of the request |

## Verification
A wrong decision shows on `rspFault` in the cycle after the offending request. A wrong decision is a bad size decode, a wrong large/small split, or a missing term in the alignment-check condition. A stale result register shows up on the next idle cycle as a nonzero code while `rspValid` is low. A broken valid pipeline shows as `rspValid` out of step with the request. Both of these appear one cycle after the cause. Mixing directed boundary addresses with random traffic exercises every size code, every kind and every flag combination, on both aligned and misaligned addresses.

// File: rtl/memalign_pkg.sv
package memalign_pkg;
  localparam int SIZE_W = 3;
  localparam int RING_W = 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PROT  = 2'b01,
    FLT_ALIGN = 2'b10
  } faultCode_t;

  typedef enum logic [1:0] {
    KIND_ALIGNED   = 2'd0,
    KIND_UNALIGNED = 2'd1,
    KIND_ARITH     = 2'd2,
    KIND_ARITH_ALT = 2'd3
  } accKind_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } stepCtl_t;
endpackage

// File: rtl/memalign_ctrl.sv
module memalign_ctrl
  import memalign_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output stepCtl_t stepCtl,
  output logic     rspValid
);
  logic validQ;

  always_comb begin
    stepCtl.capture = reqValid;
    stepCtl.clear   = ~reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= reqValid;
  end

  assign rspValid = validQ;
endmodule

// File: rtl/memalign_dp.sv
module memalign_dp
  import memalign_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int MAX_LOG   = 5,
  parameter int LARGE_LOG = 4,
  parameter int USER_RING = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          stepCtl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqExt,
  input  logic [1:0]        reqKind,
  input  logic [RING_W-1:0] reqRing,
  input  logic              chkFlag,
  input  logic              ctlAlignMask,
  output logic [1:0]        rspFault
);
  localparam logic [SIZE_W-1:0] MAX_CODE   = SIZE_W'(MAX_LOG);
  localparam logic [SIZE_W-1:0] LARGE_CODE = SIZE_W'(LARGE_LOG);
  localparam logic [RING_W-1:0] USER_CODE  = RING_W'(USER_RING);

  logic [SIZE_W-1:0]  effLog;
  logic [MAX_LOG-1:0] lowHit;
  logic               misaligned;
  logic               isLarge;
  logic               protHit;
  logic               alignHit;
  faultCode_t         faultNext;
  faultCode_t         faultQ;
  accKind_t           kind;

  assign kind   = accKind_t'(reqKind);
  assign effLog = (reqSize > MAX_CODE) ? MAX_CODE : reqSize;

  for (genvar b = 0; b < MAX_LOG; b++) begin : g_low
    assign lowHit[b] = reqAddr[b] & (SIZE_W'(b) < effLog);
  end

  assign misaligned = |lowHit;
  assign isLarge    = effLog >= LARGE_CODE;

  always_comb begin
    protHit = 1'b0;
    if (isLarge && misaligned) begin
      unique case (kind)
        KIND_ALIGNED:               protHit = 1'b1;
        KIND_UNALIGNED:             protHit = 1'b0;
        KIND_ARITH, KIND_ARITH_ALT: protHit = ~reqExt;
        default:                    protHit = 1'b0;
      endcase
    end
  end

  assign alignHit = ~isLarge & misaligned & chkFlag & ctlAlignMask &
                    (reqRing == USER_CODE);

  always_comb begin
    if (protHit)       faultNext = FLT_PROT;
    else if (alignHit) faultNext = FLT_ALIGN;
    else               faultNext = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                faultQ <= FLT_NONE;
    else if (stepCtl.capture) faultQ <= faultNext;
    else if (stepCtl.clear)   faultQ <= FLT_NONE;
  end

  assign rspFault = faultQ;
endmodule

// File: rtl/memalign_chk_top.sv
module memalign_chk_top
  import memalign_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int MAX_LOG   = 5,
  parameter int LARGE_LOG = 4,
  parameter int USER_RING = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqExt,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqRing,
  input  logic              chkFlag,
  input  logic              ctlAlignMask,
  output logic              rspValid,
  output logic [1:0]        rspFault
);
  stepCtl_t stepCtl;

  memalign_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .stepCtl(stepCtl), .rspValid(rspValid)
  );

  memalign_dp #(
    .ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG),
    .LARGE_LOG(LARGE_LOG), .USER_RING(USER_RING)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stepCtl(stepCtl),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqExt(reqExt),
    .reqKind(reqKind), .reqRing(reqRing), .chkFlag(chkFlag),
    .ctlAlignMask(ctlAlignMask), .rspFault(rspFault)
  );
endmodule

// File: rtl/memalign_sva.sv
module memalign_sva #(
  parameter int ADDR_W    = 48,
  parameter int MAX_LOG   = 5,
  parameter int LARGE_LOG = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [2:0]        reqSize,
  input logic              reqExt,
  input logic [1:0]        reqKind,
  input logic              chkFlag,
  input logic              rspValid,
  input logic [1:0]        rspFault
);
  logic offGrid;
  logic bigAcc;

  always_comb begin
    offGrid = 1'b0;
    for (int b = 0; b < MAX_LOG; b++)
      if (b < int'(reqSize) && reqAddr[b]) offGrid = 1'b1;
  end
  assign bigAcc = int'(reqSize) >= LARGE_LOG;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid));
  a_r2_no_code3: assert property (@(posedge clk) disable iff (!rstN)
    rspFault != 2'b11);
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspFault == 2'b00);
  a_r4_aligned_move_prot: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && bigAcc && offGrid && reqKind == 2'd0 |=> rspFault == 2'b01);
  a_r6_ext_arith_free: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && bigAcc && reqExt && reqKind[1] |=> rspFault == 2'b00);
  a_r7_unaligned_free: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && bigAcc && reqKind == 2'd1 |=> rspFault == 2'b00);
  a_r8_flag_off: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !chkFlag |=> rspFault != 2'b10);
  a_r9_big_no_align: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && bigAcc |=> rspFault != 2'b10);
  a_r10_on_grid: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !offGrid |=> rspFault == 2'b00);
endmodule

bind memalign_chk_top memalign_sva #(
  .ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .LARGE_LOG(LARGE_LOG)
) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqSize(reqSize), .reqExt(reqExt), .reqKind(reqKind),
  .chkFlag(chkFlag), .rspValid(rspValid), .rspFault(rspFault)
);

// File: tb/test_memalign_chk_top.sv
module test_memalign_chk_top;
  localparam int ADDR_W = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [2:0]        reqSize = 3'd0;
  logic              reqExt = 1'b0;
  logic [1:0]        reqKind = 2'd0;
  logic [1:0]        reqRing = 2'd0;
  logic              chkFlag = 1'b0;
  logic              ctlAlignMask = 1'b0;
  logic              rspValid;
  logic [1:0]        rspFault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  memalign_chk_top i_memalign_chk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqExt(reqExt), .reqKind(reqKind), .reqRing(reqRing),
    .chkFlag(chkFlag), .ctlAlignMask(ctlAlignMask),
    .rspValid(rspValid), .rspFault(rspFault)
  );

  function automatic bit offGridOf(logic [ADDR_W-1:0] a, logic [2:0] s);
    int n = (s > 3'd5) ? 5 : int'(s);
    for (int b = 0; b < n; b++) if (a[b]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [1:0] expFault(logic [ADDR_W-1:0] a, logic [2:0] s,
      logic e, logic [1:0] k, logic [1:0] r, logic f, logic m);
    bit big = s >= 3'd4;
    if (!offGridOf(a, s)) return 2'b00;
    if (big) begin
      if (k == 2'd0) return 2'b01;
      if (k == 2'd1) return 2'b00;
      return e ? 2'b00 : 2'b01;
    end
    return (f && m && r == 2'd3) ? 2'b10 : 2'b00;
  endfunction

  function automatic string tagOf(logic [ADDR_W-1:0] a, logic [2:0] s,
      logic e, logic [1:0] k);
    if (!offGridOf(a, s)) return "R10";
    if (s < 3'd4) return "R8";
    if (k == 2'd0) return "R4";
    if (k == 2'd1) return "R7";
    return e ? "R6" : "R5";
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(logic [ADDR_W-1:0] a, logic [2:0] s, logic e,
      logic [1:0] k, logic [1:0] r, logic f, logic m, string tag);
    logic [1:0] ex;
    reqValid = 1'b1; reqAddr = a; reqSize = s; reqExt = e;
    reqKind = k; reqRing = r; chkFlag = f; ctlAlignMask = m;
    ex = expFault(a, s, e, k, r, f, m);
    @(negedge clk);
    check("R1", {1'b0, rspValid}, 2'b01);
    check(tag, rspFault, ex);
  endtask

  task automatic idle();
    reqValid = 1'b0;
    reqAddr = '1; reqSize = 3'd5; reqKind = 2'd0;
    @(negedge clk);
    check("R1", {1'b0, rspValid}, 2'b00);
    check("R2", rspFault, 2'b00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [2:0] s;
    logic [1:0] k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", {1'b0, rspValid}, 2'b00);
    check("R2", rspFault, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {1'b0, rspValid}, 2'b00);

    issue(48'h1008, 3'd4, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, "R4");
    issue(48'h1010, 3'd5, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, "R4");
    issue(48'h1001, 3'd4, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, "R5");
    issue(48'h1003, 3'd5, 1'b1, 2'd3, 2'd3, 1'b1, 1'b1, "R6");
    issue(48'h100F, 3'd4, 1'b0, 2'd1, 2'd3, 1'b1, 1'b1, "R7");
    issue(48'h1002, 3'd3, 1'b0, 2'd2, 2'd3, 1'b1, 1'b1, "R8");
    issue(48'h1001, 3'd1, 1'b1, 2'd0, 2'd3, 1'b1, 1'b1, "R8");
    issue(48'h1002, 3'd2, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, "R8");
    issue(48'h1002, 3'd2, 1'b1, 2'd1, 2'd3, 1'b0, 1'b1, "R8");
    issue(48'h1002, 3'd2, 1'b1, 2'd1, 2'd3, 1'b1, 1'b0, "R8");
    issue(48'h1008, 3'd4, 1'b0, 2'd2, 2'd3, 1'b1, 1'b1, "R9");
    issue(48'h1010, 3'd7, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, "R3");
    issue(48'h1020, 3'd6, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, "R3");
    issue(48'h0FFF, 3'd0, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, "R3");
    issue(48'h1020, 3'd5, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, "R10");
    idle();
    issue(48'h1004, 3'd3, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, "R8");
    idle();

    for (int i = 0; i < 3000; i++) begin
      a = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) a[4:0] = 5'd0;
      s = 3'($urandom_range(0, 7));
      k = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) idle();
      issue(a, s, 1'($urandom), k, 2'($urandom),
            1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0),
            tagOf(a, s, 1'(reqExt), k));
    end
    idle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule